// File: doc/BRIEF.md
# Maskable Level Interrupt Status Unit

This unit gathers single-cycle event pulses from a number of internal sources into one status register that a host can read. Each source has a bit in a mask register; a set mask bit stops the source from being recorded, so a masked source never shows in the status value and never raises the interrupt line. The interrupt output is a level: it stays high while any recorded status bit is still pending.

The host finds the cause of an interrupt by reading the status value, and that read clears it. An event that arrives in the same cycle as the read is kept, so the line stays high without a gap. Writing the mask register pulls the interrupt line low for exactly one cycle. If unmasked bits are still pending, the line rises again, which gives an edge-triggered host controller a fresh edge. Setting a mask bit also discards any pending status bit of that source.

Top module: `isu_top`

## Requirements
- R1: After reset the mask register is all zeros, the status value is all zeros and `irq_o` is low.
- R2: A 1 on `evt_i[k]` in a cycle where `mask_o[k]` is 0 sets `stat_o[k]` after the next clock edge. The bit stays set until a read or a mask write clears it.
- R3: A 1 on `evt_i[k]` in a cycle where `mask_o[k]` is 1 (1 = masked) sets no status bit and does not raise `irq_o`.
- R4: Outside the cycle after a mask write, `irq_o` is 1 exactly when at least one `stat_o` bit is 1.
- R5: A cycle with `rd_stat_i` high clears every status bit at the following edge, except bits whose unmasked event arrives in that same cycle. Those bits stay set, so `irq_o` stays high.
- R6: A cycle with `wr_mask_i` high forces `irq_o` low for the one cycle after the edge. In the cycle after that, `irq_o` is high again if unmasked status bits are pending.
- R7: A mask write that sets bit k clears any pending `stat_o[k]` at the same edge. An event on source k in the write cycle is judged against the old mask and then cleared by the new one.
- R8: `mask_o` takes the value of `mask_wdata_i` at the edge that ends a `wr_mask_i` cycle and holds it otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | N_SRC | Event pulses, one per source |
| rd_stat_i | input | 1 | Host read strobe for the status value (clear on read) |
| wr_mask_i | input | 1 | Host write strobe for the mask register |
| mask_wdata_i | input | N_SRC | Mask value to write; 1 masks the source |
| stat_o | output | N_SRC | Interrupt status value |
| mask_o | output | N_SRC | Current mask register value |
| irq_o | output | 1 | Level interrupt request, active high |

## Verification
The properties assume that event pulses, read strobes and mask writes are synchronous to `clk_i` and held low while `rst_ni` is asserted. They also assume that a read and a mask write may share a cycle, and that the sticky-bit rule is only claimed for cycles with neither access. The stimulus drives every input on the falling edge from the bench's step task and keeps all strobes low during reset. It mixes reads, writes and events in the same cycle only where a requirement defines the combined result.

// File: rtl/isu_pkg.sv
package isu_pkg;
  parameter int unsigned SRC_W_DEF = 8;
endpackage

// File: rtl/isu_mask_reg.sv
module isu_mask_reg #(
  parameter int unsigned N_SRC = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [N_SRC-1:0] wdata_i,
  output logic [N_SRC-1:0] mask_o,
  output logic             blank_o
);
  logic [N_SRC-1:0] mask_q;
  logic             blank_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q  <= '0;
      blank_q <= 1'b0;
    end else begin
      blank_q <= wr_i;
      if (wr_i) mask_q <= wdata_i;
    end
  end

  assign mask_o  = mask_q;
  assign blank_o = blank_q;
endmodule

// File: rtl/isu_stat_reg.sv
module isu_stat_reg #(
  parameter int unsigned N_SRC = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] evt_i,
  input  logic             rd_i,
  input  logic             wr_i,
  input  logic [N_SRC-1:0] wdata_i,
  input  logic [N_SRC-1:0] mask_i,
  output logic [N_SRC-1:0] stat_o
);
  for (genvar k = 0; k < N_SRC; k++) begin : g_bit
    logic bit_q, bit_d, hit;

    // event is judged against the mask in force during this cycle
    assign hit = evt_i[k] & ~mask_i[k];

    always_comb begin
      bit_d = (bit_q & ~rd_i) | hit;
      if (wr_i && wdata_i[k]) bit_d = 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) bit_q <= 1'b0;
      else         bit_q <= bit_d;
    end

    assign stat_o[k] = bit_q;
  end
endmodule

// File: rtl/isu_irq_drive.sv
module isu_irq_drive #(
  parameter int unsigned N_SRC = 8
) (
  input  logic [N_SRC-1:0] stat_i,
  input  logic             blank_i,
  output logic             irq_o
);
  assign irq_o = (|stat_i) & ~blank_i;
endmodule

// File: rtl/isu_top.sv
module isu_top #(
  parameter int unsigned N_SRC = isu_pkg::SRC_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] evt_i,
  input  logic             rd_stat_i,
  input  logic             wr_mask_i,
  input  logic [N_SRC-1:0] mask_wdata_i,
  output logic [N_SRC-1:0] stat_o,
  output logic [N_SRC-1:0] mask_o,
  output logic             irq_o
);
  logic blank;

  isu_mask_reg #(.N_SRC(N_SRC)) i_mask (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_mask_i),
    .wdata_i (mask_wdata_i),
    .mask_o  (mask_o),
    .blank_o (blank)
  );

  isu_stat_reg #(.N_SRC(N_SRC)) i_stat (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .evt_i   (evt_i),
    .rd_i    (rd_stat_i),
    .wr_i    (wr_mask_i),
    .wdata_i (mask_wdata_i),
    .mask_i  (mask_o),
    .stat_o  (stat_o)
  );

  isu_irq_drive #(.N_SRC(N_SRC)) i_irq (
    .stat_i  (stat_o),
    .blank_i (blank),
    .irq_o   (irq_o)
  );
endmodule

// File: rtl/isu_chk.sv
module isu_chk #(
  parameter int unsigned N_SRC = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_SRC-1:0] evt_i,
  input logic             rd_stat_i,
  input logic             wr_mask_i,
  input logic [N_SRC-1:0] mask_wdata_i,
  input logic [N_SRC-1:0] stat_o,
  input logic [N_SRC-1:0] mask_o,
  input logic             irq_o
);
  // R3
  masked_hidden_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_o & mask_o) == '0);

  // R4
  irq_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_mask_i |=> (irq_o == (|stat_o)));

  // R6
  irq_blank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_mask_i |=> !irq_o);

  // R5
  read_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_stat_i && evt_i == '0) |=> stat_o == '0);

  // R2
  sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_stat_i && !wr_mask_i) |=> ((stat_o & $past(stat_o)) == $past(stat_o)));

  // R8
  mask_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_mask_i |=> $stable(mask_o));
endmodule

bind isu_top isu_chk #(.N_SRC(N_SRC)) i_isu_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .evt_i        (evt_i),
  .rd_stat_i    (rd_stat_i),
  .wr_mask_i    (wr_mask_i),
  .mask_wdata_i (mask_wdata_i),
  .stat_o       (stat_o),
  .mask_o       (mask_o),
  .irq_o        (irq_o)
);

// File: tb/test_isu_top.sv
module test_isu_top;
  localparam int unsigned N = 8;

  typedef struct {
    logic [N-1:0] stat;
    logic [N-1:0] mask;
    logic         irq;
    string        tag;
  } exp_t;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [N-1:0] evt_i = '0;
  logic         rd_stat_i = 1'b0;
  logic         wr_mask_i = 1'b0;
  logic [N-1:0] mask_wdata_i = '0;
  logic [N-1:0] stat_o, mask_o;
  logic         irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  exp_t sb[$];

  logic [N-1:0] m_stat = '0, m_mask = '0;

  always #2.5 clk_i = ~clk_i;

  isu_top #(.N_SRC(N)) i_isu_top (
    .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(evt_i), .rd_stat_i(rd_stat_i),
    .wr_mask_i(wr_mask_i), .mask_wdata_i(mask_wdata_i),
    .stat_o(stat_o), .mask_o(mask_o), .irq_o(irq_o)
  );

  task automatic step(input logic [N-1:0] evt, input logic rd, input logic wr,
                      input logic [N-1:0] wd, input string tag);
    exp_t e;
    logic [N-1:0] ns;
    @(negedge clk_i);
    evt_i = evt; rd_stat_i = rd; wr_mask_i = wr; mask_wdata_i = wd;
    ns = (rd ? '0 : m_stat) | (evt & ~m_mask);
    if (wr) begin
      ns     = ns & ~wd;
      m_mask = wd;
    end
    m_stat = ns;
    e.stat = ns; e.mask = m_mask; e.irq = (|ns) && !wr; e.tag = tag;
    sb.push_back(e);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk_i);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (stat_o !== e.stat || mask_o !== e.mask || irq_o !== e.irq) begin
          errors++;
          $display("FAIL %s: stat=%h mask=%h irq=%b expected stat=%h mask=%h irq=%b",
                   e.tag, stat_o, mask_o, irq_o, e.stat, e.mask, e.irq);
        end
      end
    end
  end

  initial begin : watchdog
    #100000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #12;
    checks++;
    if (stat_o !== '0 || mask_o !== '0 || irq_o !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: stat=%h mask=%h irq=%b expected 00 00 0", stat_o, mask_o, irq_o);
    end
    @(negedge clk_i); rst_ni = 1'b1;
    step(8'h01, 0, 0, 8'h00, "R2 event sets bit0");
    step(8'h00, 0, 0, 8'h00, "R2 bit holds");
    step(8'h04, 0, 0, 8'h00, "R4 second source, irq high");
    step(8'h00, 1, 0, 8'h00, "R5 read clears all");
    step(8'h00, 0, 0, 8'h00, "R4 irq low with empty status");
    step(8'h03, 0, 0, 8'h00, "R2 two sources");
    step(8'h02, 1, 0, 8'h00, "R5 event during read kept");
    step(8'h00, 0, 1, 8'h02, "R7 masking discards pending bit1, R6 blank");
    step(8'h00, 0, 0, 8'h00, "R8 mask held");
    step(8'h02, 0, 0, 8'h00, "R3 masked event ignored");
    step(8'h00, 0, 0, 8'h00, "R3 no late effect");
    step(8'h08, 0, 0, 8'h00, "R2 unmasked bit3");
    step(8'h00, 0, 1, 8'h02, "R6 rewrite blanks irq");
    step(8'h00, 0, 0, 8'h00, "R6 irq reasserts");
    step(8'h10, 0, 1, 8'h10, "R7 event in write cycle cleared by new mask");
    step(8'h00, 0, 0, 8'h00, "R8 new mask visible");
    step(8'h00, 1, 1, 8'h00, "R8 mask clear with read");
    step(8'hFF, 0, 0, 8'h00, "R2 all sources");
    step(8'h00, 1, 0, 8'h00, "R5 read clears full status");
    step(8'h00, 0, 0, 8'h00, "R4 idle");
    @(negedge clk_i); evt_i = '0; rd_stat_i = 0; wr_mask_i = 0;
    @(posedge clk_i); #2;
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule